// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external controller read and write a bank of 32 eight-bit configuration registers over a synchronous serial link. The link has four signals: an active-low select, a serial clock, a data pin that can carry traffic both ways, and an optional second pin that carries only outgoing data. The register contents are always visible on a flat parallel bus, so the rest of the chip can use them.

Every transaction begins when select falls. The first eight bits form a command byte. It gives the direction, a length of one to four data bytes, and a 5-bit start address. The data bytes follow. Each written byte takes effect at the clock edge that delivers its last bit. Register 0 sets up the port itself: one bit picks the bit order and another picks whether read data leaves on the shared pin or on the dedicated output pin. A new value in register 0 applies from the very next bit, even inside the same transaction. Raising select ends a transaction at any moment.

The block runs directly on the serial clock. Select acts as an asynchronous reset of the transaction state. A separate system reset clears the registers.

Top module: `cfg_serial_port`

## Requirements
- R1: The first 8 bits after select falls form the command. Bit 7 is the direction (1 = read, 0 = write), bits 6:5 are the length code, and bits 4:0 are the start address. Bits are captured on rising clock edges.
- R2: Length code 00, 01, 10 or 11 gives 1, 2, 3 or 4 data bytes. Clock edges after the last data byte write nothing and drive nothing.
- R3: A written register takes its new value at the rising edge that captures the last bit of its data byte. This happens before the transaction ends.
- R4: Raising select aborts the transaction at once. A partly received data byte is never written. The next fall of select starts a new command.
- R5: After each data byte the address steps. It goes down by one in MSB-first order and up by one in LSB-first order, wrapping within 0 to 31.
- R6: Register 0 bit 7 = 1 selects LSB-first order for command and data bytes. Bit 6 = 1 selects four-wire output. A write to register 0 changes the order and the step direction for all following bits of the same transaction.
- R7: Read data bits change after the falling clock edge and hold through the next rising edge. In three-wire mode they leave on `sdio_o` with `sdio_oe` high. In four-wire mode they leave on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R8: System reset clears all 32 registers to zero, which gives MSB-first, three-wire operation. Both output enables are low whenever select is high.
- R9: No output enable is high during the command byte or during a write. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | System reset, active low, clears the registers |
| sclk | input | 1 | Serial clock; inputs sampled on its rising edge |
| cs_n | input | 1 | Select, active low; high aborts and resets the transaction |
| sdio_i | input | 1 | Serial data into the block from the shared pin |
| sdio_o | output | 1 | Read data toward the shared pin |
| sdio_oe | output | 1 | Drive enable for the shared pin (three-wire reads) |
| sdo_o | output | 1 | Read data toward the dedicated output pin |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin (four-wire reads) |
| regs_flat | output | 256 | All registers; register n at bits 8n+7:8n |

## Verification
The most demanding edge is the one where a byte written to register 0 commits and the port changes its own bit order and address-step direction in the same cycle. The bench provokes it with multibyte writes that pass through address 0 partway. It then checks that the following byte is decoded in the new order and lands at the address given by the new step direction. A second collision is abort against commit: select is raised a few bits into a byte that follows a completed one. The bench expects the completed byte to be present and the partial byte to be absent.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_IDLE  = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                        sclk,
  input  logic                        cs_n,
  input  logic                        din,
  input  logic                        lsb_first,
  output phase_e                      phase,
  output logic                        rw,
  output logic [$clog2(DATA_W)-1:0]   bit_cnt,
  output logic [ADDR_W-1:0]           cur_addr,
  output logic                        wr_en,
  output logic [DATA_W-1:0]           wr_data
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int ORD_BIT = DATA_W - 1;

  phase_e              phase_q;
  logic                rw_q;
  logic [BIT_W-1:0]    bit_q;
  logic [DATA_W-2:0]   shreg_q;
  logic [CNT_W-1:0]    left_q;
  logic [ADDR_W-1:0]   addr_q;

  logic                last_bit;
  logic [DATA_W-1:0]   assembled;
  logic                lsb_after;
  logic [ADDR_W-1:0]   addr_step;

  assign last_bit  = (bit_q == BIT_W'(DATA_W - 1));
  assign assembled = lsb_first ? {din, shreg_q} : {shreg_q, din};

  // commit strobe: last bit of a write data byte
  assign wr_en   = (phase_q == PH_DATA) && !rw_q && last_bit && !cs_n;
  assign wr_data = assembled;

  // a byte that lands in register 0 decides the order from here on
  assign lsb_after = (wr_en && addr_q == '0) ? assembled[ORD_BIT] : lsb_first;
  assign addr_step = lsb_after ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      phase_q <= PH_INSTR;
      rw_q    <= 1'b0;
      bit_q   <= '0;
      shreg_q <= '0;
      left_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (phase_q != PH_IDLE) begin
        bit_q   <= last_bit ? '0 : bit_q + BIT_W'(1);
        shreg_q <= lsb_first ? assembled[DATA_W-1:1] : assembled[DATA_W-2:0];
      end
      case (phase_q)
        PH_INSTR: if (last_bit) begin
          rw_q    <= assembled[DATA_W-1];
          left_q  <= assembled[DATA_W-2 -: CNT_W];
          addr_q  <= assembled[ADDR_W-1:0];
          phase_q <= PH_DATA;
        end
        PH_DATA: if (last_bit) begin
          addr_q <= addr_step;
          if (left_q == '0) phase_q <= PH_IDLE;
          else              left_q  <= left_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign phase    = phase_q;
  assign rw       = rw_q;
  assign bit_cnt  = bit_q;
  assign cur_addr = addr_q;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                           sclk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic [(DATA_W<<ADDR_W)-1:0]    regs_flat
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))     q <= wr_data;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

  assign rd_data = regs_flat[rd_addr*DATA_W +: DATA_W];
endmodule

// File: rtl/spi_tx_drv.sv
module spi_tx_drv
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        sclk,
  input  logic                        cs_n,
  input  phase_e                      phase,
  input  logic                        rw,
  input  logic [$clog2(DATA_W)-1:0]   bit_cnt,
  input  logic                        lsb_first,
  input  logic                        four_wire,
  input  logic [DATA_W-1:0]           rd_byte,
  output logic                        sdio_o,
  output logic                        sdio_oe,
  output logic                        sdo_o,
  output logic                        sdo_oe
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] TOP = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0] sel;
  logic             bit_q;
  logic             act_q;

  assign sel = lsb_first ? bit_cnt : TOP - bit_cnt;

  // launched on the falling edge, sampled by the master on the next rise
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      bit_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      bit_q <= rd_byte[sel];
      act_q <= (phase == PH_DATA) && rw;
    end
  end

  assign sdio_o  = bit_q;
  assign sdo_o   = bit_q;
  assign sdio_oe = act_q && !four_wire;
  assign sdo_oe  = act_q && four_wire;
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                         rst_n,
  input  logic                         sclk,
  input  logic                         cs_n,
  input  logic                         sdio_i,
  output logic                         sdio_o,
  output logic                         sdio_oe,
  output logic                         sdo_o,
  output logic                         sdo_oe,
  output logic [(DATA_W<<ADDR_W)-1:0]  regs_flat
);
  localparam int CNT_W    = DATA_W - 1 - ADDR_W;
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int ORD_BIT  = DATA_W - 1;
  localparam int WIRE_BIT = DATA_W - 2;

  phase_e              phase;
  logic                rw_q;
  logic [BIT_W-1:0]    bit_cnt;
  logic [ADDR_W-1:0]   cur_addr;
  logic                wr_en;
  logic [DATA_W-1:0]   wr_data;
  logic [DATA_W-1:0]   rd_data;
  logic                lsb_first;
  logic                four_wire;

  assign lsb_first = regs_flat[ORD_BIT];
  assign four_wire = regs_flat[WIRE_BIT];

  spi_rx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .din       (sdio_i),
    .lsb_first (lsb_first),
    .phase     (phase),
    .rw        (rw_q),
    .bit_cnt   (bit_cnt),
    .cur_addr  (cur_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  spi_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (cur_addr),
    .wr_data   (wr_data),
    .rd_addr   (cur_addr),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

  spi_tx_drv #(.DATA_W(DATA_W)) u_tx (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .phase     (phase),
    .rw        (rw_q),
    .bit_cnt   (bit_cnt),
    .lsb_first (lsb_first),
    .four_wire (four_wire),
    .rd_byte   (rd_data),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe),
    .sdo_o     (sdo_o),
    .sdo_oe    (sdo_oe)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import spi_cfg_pkg::*;
#(
  parameter int REGS_W = 256
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdio_oe,
  input logic              sdo_oe,
  input logic              wr_en,
  input logic              rw,
  input phase_e            phase,
  input logic [REGS_W-1:0] regs_flat
);
  AST_OE_EXCLUSIVE: assert property (@(posedge sclk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe)); // R9

  AST_DRIVE_ONLY_READ: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (sdio_oe || sdo_oe) |-> (rw && phase == PH_DATA)); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (phase == PH_IDLE) |=> $stable(regs_flat)); // R2

  AST_COMMIT_ONLY_ON_STROBE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    !wr_en |=> $stable(regs_flat)); // R3

  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !(sdio_oe || sdo_oe)); // R8
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.REGS_W(DATA_W << ADDR_W)) u_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sdio_oe   (sdio_oe),
  .sdo_oe    (sdo_oe),
  .wr_en     (wr_en),
  .rw        (rw_q),
  .phase     (phase),
  .regs_flat (regs_flat)
);

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;
  logic         rst_n = 1'b0;
  logic         sclk  = 1'b0;
  logic         cs_n  = 1'b1;
  logic         sdio_i = 1'b0;
  logic         sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [255:0] regs_flat;

  always #5 sclk = ~sclk;

  cfg_serial_port uut (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .regs_flat(regs_flat)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model built from the requirements
  logic [7:0]  m_regs [32];
  logic        m_lsb, m_4w;
  logic [31:0] rd_word;
  int          oe_io, oe_o;

  // {command, write data (first byte in low bits), expected read word}
  localparam logic [71:0] VEC [7] = '{
    {8'h6A, 32'h44332211, 32'h00000000},
    {8'hEA, 32'h00000000, 32'h44332211},
    {8'h1F, 32'h0000005A, 32'h00000000},
    {8'hA0, 32'h00000000, 32'h00005A00},
    {8'h52, 32'h00C3B2A1, 32'h00000000},
    {8'h91, 32'h00000000, 32'h000000B2},
    {8'hC7, 32'h00000000, 32'h00000044}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    int bad = 0;
    for (int a = 0; a < 32; a++)
      if (regs_flat[8*a +: 8] !== m_regs[a]) bad++;
    check(req, bad, 0);
  endtask

  task automatic model_reset();
    for (int a = 0; a < 32; a++) m_regs[a] = 8'h00;
    m_lsb = 1'b0;
    m_4w  = 1'b0;
  endtask

  // clock nbits through one transaction, then raise select
  task automatic xfer(input logic [7:0] ins, input logic [31:0] wd, input int nbits);
    logic [7:0] cur;
    logic [4:0] addr;
    int nbytes;
    rd_word = '0; oe_io = 0; oe_o = 0;
    addr   = ins[4:0];
    nbytes = int'(ins[6:5]) + 1;
    for (int k = 0; k < nbits; k++) begin
      int bt = k / 8;
      int bi = k % 8;
      cur = (bt == 0) ? ins : ((bt <= 4) ? wd[8*(bt-1) +: 8] : 8'h00);
      @(negedge sclk);
      #1;
      cs_n   = 1'b0;
      sdio_i = m_lsb ? cur[bi] : cur[7-bi];
      #3;
      if (sdio_oe) oe_io++;
      if (sdo_oe)  oe_o++;
      if (bt >= 1 && bt <= nbytes)
        rd_word[8*(bt-1) + (m_lsb ? bi : 7-bi)] = m_4w ? sdo_o : sdio_o;
      if (bi == 7 && bt >= 1 && bt <= nbytes) begin
        if (!ins[7]) begin
          m_regs[addr] = cur;
          if (addr == 5'd0) begin
            m_lsb = cur[7];
            m_4w  = cur[6];
          end
        end
        addr = m_lsb ? addr + 5'd1 : addr - 5'd1;
      end
    end
    @(negedge sclk);
    #1;
    cs_n   = 1'b1;
    sdio_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge sclk);
    // R8: reset state
    check("R8 regs after reset", regs_flat[31:0] | regs_flat[255:224], 32'h0);
    check_regs("R8 all regs zero");
    check("R8 enables low", {30'h0, sdio_oe, sdo_oe}, 32'h0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge sclk);

    // R1 R2 R5 R7: table of MSB-first, three-wire transactions
    for (int v = 0; v < 7; v++) begin
      logic [7:0]  ins;
      logic [31:0] wd, exp;
      int nb;
      ins = VEC[v][71:64];
      wd  = VEC[v][63:32];
      exp = VEC[v][31:0];
      nb  = int'(ins[6:5]) + 1;
      xfer(ins, wd, 8 * (nb + 1));
      if (ins[7]) begin
        check("R1 R5 R7 read data", rd_word, exp);
        check("R7 R9 shared pin enable bits", oe_io, 8 * nb);
        check("R7 dedicated pin quiet in three-wire", oe_o, 0);
      end else begin
        check_regs("R1 R3 R5 write contents");
        check("R9 no drive during write", oe_io + oe_o, 0);
      end
    end

    // R2: clocks past the byte count are ignored
    xfer(8'h0C, 32'h005566E1, 8 + 8 + 16);
    check("R2 extra bytes not written", {24'h0, regs_flat[8*11 +: 8]}, 32'h0);
    check_regs("R2 one-byte write only");

    // R4 R3: abort in second byte; first byte already committed
    xfer(8'h34, 32'h0000EE77, 8 + 8 + 5);
    check("R3 first byte committed", {24'h0, regs_flat[8*20 +: 8]}, 32'h77);
    check("R4 partial byte dropped", {24'h0, regs_flat[8*19 +: 8]}, 32'h00);
    xfer(8'h94, 32'h0, 16);
    check("R4 restart after abort", rd_word, 32'h77);

    // R6: write reg 1 then reg 0 (switch to LSB-first), MSB-first command
    xfer(8'h21, 32'h0000803C, 24);
    check_regs("R6 mode byte written");
    check("R6 order bit set", {31'h0, regs_flat[7]}, 32'h1);
    // R5 R6: LSB-first read climbs from 0x1F and wraps to 0x00
    xfer(8'hBF, 32'h0, 24);
    check("R5 R6 increment wrap read", rd_word, 32'h0000805A);
    // R6: mid-transfer switch back to MSB-first, four-wire; next byte uses new order
    xfer(8'h20, 32'h00009940, 24);
    check_regs("R6 mid-transfer switch applied");
    check("R6 byte after switch at 0x1F", {24'h0, regs_flat[8*31 +: 8]}, 32'h99);

    // R7: four-wire read uses dedicated pin only
    xfer(8'h92, 32'h0, 16);
    check("R7 four-wire read data", rd_word, 32'hA1);
    check("R7 dedicated pin enable bits", oe_o, 8);
    check("R7 shared pin quiet in four-wire", oe_io, 0);

    // R8: system reset clears everything again
    @(negedge sclk);
    rst_n = 1'b0;
    model_reset();
    @(negedge sclk);
    check_regs("R8 reset clears bank");
    rst_n = 1'b1;
    xfer(8'h05, 32'h00000081, 16);
    xfer(8'h85, 32'h0, 16);
    check("R8 MSB-first three-wire after reset", rd_word, 32'h81);
    check("R8 shared pin used after reset", oe_io, 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule